// File: doc/BRIEF.md
# Banked GPIO Data and Direction Port

This block is a memory-mapped general-purpose I/O port built from a parameterised number of 32-pin banks. Each bank holds a direction word and an output latch. Two more words let software raise or drop individual output bits in one bus write, with no read-modify-write sequence, so two agents can never undo each other's changes. A read-only word returns the pin levels after they cross into the core clock domain.

The port sits on a simple single-cycle register bus. A write takes effect on the rising edge where the write enable is high. Read data is combinational from the address, so it is valid in the same cycle. Pins drive their output value at all times, and the output enable is high exactly where the direction bit is 0. The synchronized pin levels also leave the block on their own output. A neighbouring edge-detect block uses them, so both blocks see the same sampled levels.

Top module: `gpio_bank_port`

## Requirements
- R1: While reset is held and right after it is released, every direction bit reads 1, every output latch bit reads 0, `pin_oe` is all 0 and `pin_out` is all 0.
- R2: A direction bit of 1 makes its pin an input and a 0 makes it an output. `pin_oe` for a pin is the inverse of its direction bit. `pin_out` always shows the output latch, whatever the direction.
- R3: A write to the set word (bank offset 0x08) drives to 1 every latch bit whose data bit is 1. Latch bits whose data bit is 0 keep their value.
- R4: A write to the clear word (bank offset 0x0C) drives to 0 every latch bit whose data bit is 1. Latch bits whose data bit is 0 keep their value.
- R5: A write to the output word (bank offset 0x04) loads the whole latch. Reads of the output word, the set word and the clear word all return the current latch.
- R6: The input word (bank offset 0x10) returns pin levels through a two-flop synchronizer. A pin change made between two rising edges is not visible after the first of them and is visible after the second. This holds for output pins too, and the synchronizer resets to 0.
- R7: Bank b starts at byte address 0x10 + 0x28*b. The direction word sits at bank offset 0x00 and can be read and written. Bank b owns pins 32*b to 32*b+31, and bit i of every word maps to pin 32*b+i.
- R8: Addresses outside the five bank words read 0 and ignore writes. These are the addresses below 0x10, offsets 0x14 to 0x27 inside each bank stride, addresses past the last bank, and any address whose two low bits are not 00. A write to the input word changes nothing either.
- R9: `pin_sync` carries the same synchronized levels that the input words return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 32*NUM_BANKS | Raw pin levels from the pads |
| pin_out | output | 32*NUM_BANKS | Output latch value per pin |
| pin_oe | output | 32*NUM_BANKS | Output enable per pin, high for output |
| pin_sync | output | 32*NUM_BANKS | Synchronized pin levels, shared with the edge-detect block |

## Verification
The hardest case to reach is the synchronizer lag. The bench must show an input word still holding the old level one edge after a pin change and the new level one edge later. The directed part changes `pin_in` on a falling edge and reads on each of the next two falling edges. A second hard case is proving that set and clear leave unselected bits alone. For this, random set, clear, load and direction writes run against a bench model of every bank, with random pin levels changing between operations. Probes of the unmapped holes between bank strides, misaligned addresses and writes to the input word then check that no pin or register moved.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
   localparam int unsigned BANK_W           = 32;
   localparam int unsigned FIRST_BANK_BYTE  = 'h10;
   localparam int unsigned BANK_STRIDE_BYTE = 'h28;
   localparam int unsigned WORDS_USED       = 5;

   // Word order inside a bank is part of the address map.
   typedef enum logic [2:0] {
      WSEL_DIR  = 3'd0,
      WSEL_OUT  = 3'd1,
      WSEL_SET  = 3'd2,
      WSEL_CLR  = 3'd3,
      WSEL_IN   = 3'd4,
      WSEL_NONE = 3'd7
   } wsel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output wsel_e                wsel
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0]          word;
   logic                       aligned;
   logic [NUM_BANKS-1:0][2:0]  offs;

   assign word    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BASE_WORD =
         (FIRST_BANK_BYTE / 4) + b * (BANK_STRIDE_BYTE / 4);
      logic [WORD_W:0] rel;
      logic            above;
      assign rel   = {1'b0, word} - (WORD_W+1)'(BASE_WORD);
      assign above = ({1'b0, word} >= (WORD_W+1)'(BASE_WORD));
      assign bank_hit[b] = aligned && above && (rel < (WORD_W+1)'(WORDS_USED));
      assign offs[b]     = rel[2:0];
   end

   always_comb begin
      wsel = WSEL_NONE;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) wsel = wsel_e'(offs[b]);
      end
   end
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = BANK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  wsel_e            wsel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         out_q <= '0;
      end else if (wr_en) begin
         case (wsel)
            WSEL_DIR: dir_q <= wdata;
            WSEL_OUT: out_q <= wdata;
            WSEL_SET: out_q <= out_q | wdata;
            WSEL_CLR: out_q <= out_q & ~wdata;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_port.sv
`timescale 1ns/1ps
module gpio_bank_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [BANK_W-1:0]   bus_wdata,
   output logic [BANK_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_sync
);
   localparam longint unsigned MAP_END =
      FIRST_BANK_BYTE + longint'(BANK_STRIDE_BYTE) * NUM_BANKS;

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_bank_port: NUM_BANKS must be at least 1");
   end
   if (ADDR_W < 6 || ADDR_W > 31) begin : g_bad_addr_w
      $error("gpio_bank_port: ADDR_W out of range");
   end else if (MAP_END > (longint'(1) << ADDR_W)) begin : g_bad_map
      $error("gpio_bank_port: address map does not fit in ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_bank_port: SYNC_STAGES must be at least 2");
   end

   logic [NUM_BANKS-1:0]             bank_hit;
   wsel_e                            wsel;
   logic [NUM_BANKS-1:0][BANK_W-1:0] dir_q;
   logic [NUM_BANKS-1:0][BANK_W-1:0] out_q;

   gpio_addr_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_decode (
      .addr     (bus_addr),
      .bank_hit (bank_hit),
      .wsel     (wsel)
   );

   gpio_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_bank_regs #(
         .WIDTH (BANK_W)
      ) u_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (bus_we && bank_hit[b]),
         .wsel  (wsel),
         .wdata (bus_wdata),
         .dir_q (dir_q[b]),
         .out_q (out_q[b])
      );
      assign pin_out[b*BANK_W +: BANK_W] = out_q[b];
      assign pin_oe [b*BANK_W +: BANK_W] = ~dir_q[b];
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) begin
            case (wsel)
               WSEL_DIR:                     bus_rdata = dir_q[b];
               WSEL_OUT, WSEL_SET, WSEL_CLR: bus_rdata = out_q[b];
               WSEL_IN:                      bus_rdata = pin_sync[b*BANK_W +: BANK_W];
               default:                      bus_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_bank_port_chk.sv
`timescale 1ns/1ps
module gpio_bank_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [BANK_W-1:0]   bus_wdata,
   input logic [BANK_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_sync
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R8: idle cycles leave every pin output alone
   a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

   // R8: the hole below the first bank reads zero and ignores writes
   a_r8_low_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < ADDR_W'(FIRST_BANK_BYTE)) |-> (bus_rdata == '0));
   a_r8_low_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr < ADDR_W'(FIRST_BANK_BYTE)) |=>
         ($stable(pin_out) && $stable(pin_oe)));

   if (SYNC_STAGES == 2) begin : g_sync2
      // R6: two-edge lag from pad to synchronized level
      a_r6_two_stage_lag: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BASE = FIRST_BANK_BYTE + b * BANK_STRIDE_BYTE;

      a_r2_oe_from_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE)) |=>
            (pin_oe[b*BANK_W +: BANK_W] == ~$past(bus_wdata)));

      a_r3_set_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE + 8)) |=>
            ((pin_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata)));
      a_r3_set_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE + 8)) |=>
            ((pin_out[b*BANK_W +: BANK_W] & ~$past(bus_wdata)) ==
             ($past(pin_out[b*BANK_W +: BANK_W]) & ~$past(bus_wdata))));

      a_r4_clear_forces_zeros: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE + 12)) |=>
            ((pin_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == '0));
      a_r4_clear_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE + 12)) |=>
            ((pin_out[b*BANK_W +: BANK_W] & ~$past(bus_wdata)) ==
             ($past(pin_out[b*BANK_W +: BANK_W]) & ~$past(bus_wdata))));

      a_r5_load_whole_latch: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(BASE + 4)) |=>
            (pin_out[b*BANK_W +: BANK_W] == $past(bus_wdata)));

      a_r9_input_word_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == ADDR_W'(BASE + 16)) |->
            (bus_rdata == pin_sync[b*BANK_W +: BANK_W]));
   end
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_bank_port_tb.sv
`timescale 1ns/1ps
module gpio_bank_port_tb;
   localparam int NB = 2;
   localparam int AW = 12;
   localparam int NP = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, pin_sync;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] m_dir [NB];
   logic [31:0] m_out [NB];

   always #5 clk = ~clk;

   gpio_bank_port #(.NUM_BANKS(NB), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_sync(pin_sync));

   function automatic logic [AW-1:0] ra(int b, int w);
      return AW'(32'h10 + 32'h28 * b + 4 * w);
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v;
      for (int b = 0; b < NB; b++) v[b*32 +: 32] = ~m_dir[b];
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_out();
      logic [NP-1:0] v;
      for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_out[b];
      return v;
   endfunction

   task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; write lands on the next rising edge
   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = '0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = '0;
   endtask

   task automatic pins_ok(string tag);
      chk({tag, " pin_out"}, pin_out, exp_out());
      chk({tag, " pin_oe"}, pin_oe, exp_oe());
   endtask

   task automatic regs_ok(string tag, int b);
      logic [31:0] d;
      rd(ra(b, 0), d); chk({tag, " dir"}, NP'(d), NP'(m_dir[b]));
      rd(ra(b, 1), d); chk({tag, " out"}, NP'(d), NP'(m_out[b]));
      rd(ra(b, 2), d); chk({tag, " set-word read"}, NP'(d), NP'(m_out[b]));
      rd(ra(b, 3), d); chk({tag, " clr-word read"}, NP'(d), NP'(m_out[b]));
   endtask

   task automatic model_wr(int b, int w, logic [31:0] d);
      case (w)
         0: m_dir[b] = d;
         1: m_out[b] = d;
         2: m_out[b] = m_out[b] | d;
         3: m_out[b] = m_out[b] & ~d;
         default: ;
      endcase
   endtask

   function automatic logic [NP-1:0] rnd_pins();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i += 32) v[i +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0]   d;
      logic [NP-1:0] a_lvl, b_lvl, snap_out, snap_oe;
      void'($urandom(32'd20240607));
      for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end

      // R1: reset state, during and after reset
      pin_in = rnd_pins();
      repeat (3) @(negedge clk);
      pins_ok("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      pins_ok("R1 after reset");
      for (int b = 0; b < NB; b++) regs_ok("R1", b);

      // R6/R9: two-edge synchronizer lag
      a_lvl = rnd_pins();
      pin_in = a_lvl;
      repeat (3) @(negedge clk);
      b_lvl = ~a_lvl;
      pin_in = b_lvl;
      @(negedge clk);
      rd(ra(0, 4), d); chk("R6 one edge old b0", NP'(d), NP'(a_lvl[31:0]));
      rd(ra(1, 4), d); chk("R6 one edge old b1", NP'(d), NP'(a_lvl[63:32]));
      chk("R9 pin_sync old", pin_sync, a_lvl);
      @(negedge clk);
      rd(ra(0, 4), d); chk("R6 two edges new b0", NP'(d), NP'(b_lvl[31:0]));
      rd(ra(1, 4), d); chk("R6 two edges new b1", NP'(d), NP'(b_lvl[63:32]));
      chk("R9 pin_sync new", pin_sync, b_lvl);

      // R2/R7: direction per bank, outputs still read pin levels (R6)
      wr(ra(0, 0), 32'h0000_FFFF); model_wr(0, 0, 32'h0000_FFFF);
      wr(ra(1, 0), 32'hA5A5_0F0F); model_wr(1, 0, 32'hA5A5_0F0F);
      pins_ok("R2 R7 dir per bank");
      wr(ra(0, 1), 32'h1234_5678); model_wr(0, 1, 32'h1234_5678);
      pins_ok("R2 out drives while input");
      rd(ra(0, 4), d); chk("R6 output pins read pad", NP'(d), NP'(pin_in[31:0]));

      // R3/R4 directed corners
      wr(ra(0, 2), 32'h0); model_wr(0, 2, 32'h0);
      pins_ok("R3 set with zero");
      wr(ra(0, 2), 32'h8000_0001); model_wr(0, 2, 32'h8000_0001);
      pins_ok("R3 set edge bits");
      wr(ra(1, 3), 32'hFFFF_FFFF); model_wr(1, 3, 32'hFFFF_FFFF);
      pins_ok("R4 clear all");
      wr(ra(0, 3), 32'h0000_0078); model_wr(0, 3, 32'h0000_0078);
      pins_ok("R4 clear some");
      regs_ok("R5 readback", 0);

      // random mix of set, clear, load and direction writes
      for (int i = 0; i < 400; i++) begin
         int b = $urandom_range(NB - 1, 0);
         int w = $urandom_range(3, 0);
         logic [31:0] v = $urandom;
         pin_in = rnd_pins();
         wr(ra(b, w), v); model_wr(b, w, v);
         case (w)
            0: pins_ok("R2 random dir");
            1: pins_ok("R5 random load");
            2: pins_ok("R3 random set");
            default: pins_ok("R4 random clear");
         endcase
         regs_ok("R5 random readback", b);
         @(negedge clk);
         rd(ra(b, 4), d); chk("R6 random input", NP'(d), NP'(pin_in[b*32 +: 32]));
         chk("R9 random pin_sync", pin_sync, pin_in);
      end

      // R8: unmapped holes, misaligned and input-word writes
      begin
         logic [AW-1:0] holes [8] = '{12'h000, 12'h00C, 12'h024, 12'h034,
                                      12'h060, 12'hFFC, 12'h011, 12'h03A};
         for (int k = 0; k < 8; k++) begin
            snap_out = pin_out; snap_oe = pin_oe;
            wr(holes[k], $urandom);
            chk("R8 hole write pin_out", pin_out, snap_out);
            chk("R8 hole write pin_oe", pin_oe, snap_oe);
            rd(holes[k], d); chk("R8 hole reads zero", NP'(d), '0);
         end
         for (int b = 0; b < NB; b++) begin
            wr(ra(b, 4), $urandom);
            pins_ok("R8 input word write");
            regs_ok("R8 input word write", b);
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule